// File: doc/BRIEF.md
# Multi-bank SRAM access router

The router connects several bus masters to four independent on-chip SRAM banks. Each master drives a single-cycle request port carrying an address, an access size, a write enable and write data. Masters that address different banks are all served in the same cycle with no wait states. When masters collide on one bank, a fixed priority picks the winner and holds the others back through their ready signals.

The block decodes each address against the bank windows and checks the master's rights to the bank. It also checks alignment, places narrow write data on the right byte lanes and returns narrow read data in the low bits. One bank answers only the processor data port, which is master index `CPU_DATA_IDX`. A fourth bank is present only when `HAS_EXT_BANK` is set.

Storage depth per bank is a parameter, so simulation can use small arrays. The address windows keep their full nominal size.

Top module: `sram_bank_router`

## Requirements
- R1: Bank windows are: main bank 0x2000_0000..0x2001_BFFF (112 KB), small bank 0x2001_C000..0x2001_FFFF (16 KB), core bank 0x1000_0000..0x1000_FFFF (64 KB), and extension bank 0x2002_0000..0x2002_FFFF (64 KB, only when HAS_EXT_BANK=1). A write followed by a read at the same address returns the written data.
- R2: The size field encodes 0 = byte, 1 = halfword and 2 = word. A write stores wdata[7:0] for a byte, wdata[15:0] for a halfword and all 32 bits for a word, at the byte lanes addressed by addr[1:0]. No other byte changes.
- R3: Read data is zero-extended and placed at rdata bit 0. For a byte read it is the byte at addr[1:0]; for a halfword read it is the halfword at addr[1:0].
- R4: An accepted request sees ready high in its own cycle. Its read data appears on rdata in the next cycle.
- R5: Two masters addressing different banks in the same cycle both see ready high and are both served.
- R6: When several valid requests address one bank in a cycle, the lowest master index wins. Every other master sees ready low, and nothing is done for it. Master 0 therefore never waits. A master that is not requesting, or whose request is flagged with an error, sees ready high.
- R7: The core bank accepts requests only from master CPU_DATA_IDX (default 0). A request from any other master returns err and does not change memory.
- R8: A request outside every window returns err and changes no memory. This includes the extension window when HAS_EXT_BANK=0.
- R9: A halfword at an odd address, a word whose addr[1:0] is not 0, and size code 3 all return err and change no memory.
- R10: err is high in the cycle after the offending request, and rdata is 0 in that cycle. After reset, err and rdata are 0.
- R11: Each bank stores its parameter number of words. A byte offset in a window beyond the stored size aliases onto the offset modulo the stored size in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NUM_MASTERS | Request per master |
| m_addr | input | 32*NUM_MASTERS | Byte address per master |
| m_size | input | 2*NUM_MASTERS | Access size per master (0 byte, 1 half, 2 word) |
| m_we | input | NUM_MASTERS | Write enable per master |
| m_wdata | input | 32*NUM_MASTERS | Write data per master, narrow data in the low bits |
| m_ready | output | NUM_MASTERS | Request accepted this cycle |
| m_rdata | output | 32*NUM_MASTERS | Read data, one cycle after acceptance |
| m_err | output | NUM_MASTERS | Error flag, one cycle after the request |

## Verification
The hardest situation to reach is a same-bank collision that coincides with other activity: a loser is stalled while a third master is served elsewhere or is flagged with an error. Only the exact pairing of addresses in one cycle reveals whether priority and rights are combined correctly.

The random stimulus keeps every address inside the first 64 bytes of each window, plus a small alias region and two unmapped spots, so collisions happen often. Directed cycles force the specific pairs: processor against DMA, and processor system port against DMA. A bench model predicts ready, err and read data every cycle.

// File: rtl/sram_router_pkg.sv
package sram_router_pkg;

   localparam int NUM_BANKS = 4;
   localparam int BANK_MAIN = 0;
   localparam int BANK_SMALL = 1;
   localparam int BANK_CORE = 2;
   localparam int BANK_EXT = 3;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_t;

   function automatic logic [31:0] bank_base(input int b);
      case (b)
         BANK_MAIN:  return 32'h2000_0000;
         BANK_SMALL: return 32'h2001_C000;
         BANK_CORE:  return 32'h1000_0000;
         default:    return 32'h2002_0000;
      endcase
   endfunction

   function automatic logic [31:0] bank_span(input int b);
      case (b)
         BANK_MAIN:  return 32'h0001_C000;
         BANK_SMALL: return 32'h0000_4000;
         default:    return 32'h0001_0000;
      endcase
   endfunction

   function automatic logic [3:0] lane_enable(input acc_size_t sz, input logic [1:0] lo);
      case (sz)
         SZ_BYTE: return 4'b0001 << lo;
         SZ_HALF: return 4'b0011 << lo;
         SZ_WORD: return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [31:0] lane_write(input acc_size_t sz, input logic [31:0] d);
      case (sz)
         SZ_BYTE: return {4{d[7:0]}};
         SZ_HALF: return {2{d[15:0]}};
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] lane_read(input acc_size_t sz, input logic [1:0] lo,
                                             input logic [31:0] w);
      logic [31:0] s;
      s = w >> {lo, 3'b000};
      case (sz)
         SZ_BYTE: return {24'd0, s[7:0]};
         SZ_HALF: return {16'd0, s[15:0]};
         default: return s;
      endcase
   endfunction

endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode
   import sram_router_pkg::*;
#(
   parameter int MASTER_ID    = 0,
   parameter int CPU_DATA_IDX = 0,
   parameter bit HAS_EXT_BANK = 1'b1
) (
   input  logic                 req,
   input  logic [31:0]          addr,
   input  logic [1:0]           size,
   output logic [NUM_BANKS-1:0] hit,
   output logic                 ok,
   output logic                 bad
);

   logic [NUM_BANKS-1:0] win;
   logic                 allowed;
   logic                 aligned;
   acc_size_t            sz;

   assign sz = acc_size_t'(size);

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         win[b] = ((addr - bank_base(b)) < bank_span(b));
      end
      if (!HAS_EXT_BANK) win[BANK_EXT] = 1'b0;
   end

   // R7: core bank restricted to the processor data port
   assign allowed = !win[BANK_CORE] || (MASTER_ID == CPU_DATA_IDX);

   // R9: natural alignment, size code 3 never valid
   always_comb begin
      case (sz)
         SZ_BYTE: aligned = 1'b1;
         SZ_HALF: aligned = !addr[0];
         SZ_WORD: aligned = (addr[1:0] == 2'b00);
         default: aligned = 1'b0;
      endcase
   end

   assign ok  = req && (|win) && allowed && aligned;
   assign bad = req && !ok;
   assign hit = ok ? win : '0;

endmodule

// File: rtl/sram_fixed_prio_arb.sv
module sram_fixed_prio_arb #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   a_r6_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r6_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> gnt[0]);
   a_r6_someone_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt));

endmodule

// File: rtl/sram_bank_mem.sv
module sram_bank_mem #(
   parameter int WORDS = 256,
   localparam int IW = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic [3:0]    be,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);

   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) begin
            for (int k = 0; k < 4; k++) begin
               if (be[k]) mem[idx][k*8 +: 8] <= wdata[k*8 +: 8];
            end
         end else begin
            rdata <= mem[idx];
         end
      end
   end

endmodule

// File: rtl/sram_bank_router.sv
module sram_bank_router
   import sram_router_pkg::*;
#(
   parameter int NUM_MASTERS  = 3,
   parameter int CPU_DATA_IDX = 0,
   parameter bit HAS_EXT_BANK = 1'b1,
   parameter int MAIN_WORDS   = 256,
   parameter int SMALL_WORDS  = 128,
   parameter int CORE_WORDS   = 256,
   parameter int EXT_WORDS    = 256
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_MASTERS-1:0]    m_req,
   input  logic [32*NUM_MASTERS-1:0] m_addr,
   input  logic [2*NUM_MASTERS-1:0]  m_size,
   input  logic [NUM_MASTERS-1:0]    m_we,
   input  logic [32*NUM_MASTERS-1:0] m_wdata,
   output logic [NUM_MASTERS-1:0]    m_ready,
   output logic [32*NUM_MASTERS-1:0] m_rdata,
   output logic [NUM_MASTERS-1:0]    m_err
);

   function automatic int words_of(input int b);
      case (b)
         BANK_MAIN:  return MAIN_WORDS;
         BANK_SMALL: return SMALL_WORDS;
         BANK_CORE:  return CORE_WORDS;
         default:    return EXT_WORDS;
      endcase
   endfunction

   // elaboration-time parameter checks
   if (NUM_MASTERS < 2) begin : g_bad_masters
      $error("NUM_MASTERS must be at least 2");
   end
   if (CPU_DATA_IDX < 0 || CPU_DATA_IDX >= NUM_MASTERS) begin : g_bad_cpu
      $error("CPU_DATA_IDX out of range");
   end
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      if ((words_of(b) & (words_of(b) - 1)) != 0 || words_of(b) < 2) begin : g_pow2
         $error("bank depth must be a power of two of at least 2");
      end
      if (words_of(b) * 4 > int'(bank_span(b))) begin : g_fit
         $error("bank depth exceeds its address window");
      end
   end

   logic [NUM_BANKS-1:0]   hit     [NUM_MASTERS];
   logic [NUM_MASTERS-1:0] ok;
   logic [NUM_MASTERS-1:0] bad;
   logic [NUM_MASTERS-1:0] gnt     [NUM_BANKS];
   logic [NUM_MASTERS-1:0] granted;
   logic [31:0]            bank_rd [NUM_BANKS];

   // per-master decode and response registers
   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_m
      logic [1:0] rsp_bank;
      logic [1:0] rsp_lo;
      acc_size_t  rsp_size;
      logic       rsp_rd;
      logic       rsp_err;
      logic [1:0] hit_idx;

      sram_addr_decode #(
         .MASTER_ID   (m),
         .CPU_DATA_IDX(CPU_DATA_IDX),
         .HAS_EXT_BANK(HAS_EXT_BANK)
      ) u_dec (
         .req (m_req[m]),
         .addr(m_addr[m*32 +: 32]),
         .size(m_size[m*2 +: 2]),
         .hit (hit[m]),
         .ok  (ok[m]),
         .bad (bad[m])
      );

      always_comb begin
         hit_idx = '0;
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[m][b]) hit_idx = 2'(b);
         end
      end

      assign m_ready[m] = !(ok[m] && !granted[m]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_rd   <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_bank <= '0;
            rsp_lo   <= '0;
            rsp_size <= SZ_BYTE;
         end else begin
            rsp_rd   <= granted[m] && !m_we[m];
            rsp_err  <= bad[m];
            rsp_bank <= hit_idx;
            rsp_lo   <= m_addr[m*32 +: 2];
            rsp_size <= acc_size_t'(m_size[m*2 +: 2]);
         end
      end

      assign m_err[m] = rsp_err;
      assign m_rdata[m*32 +: 32] = rsp_rd ? lane_read(rsp_size, rsp_lo, bank_rd[rsp_bank]) : '0;

      a_r8_bad_gives_err: assert property (@(posedge clk) disable iff (!rst_n)
         m_req[m] && bad[m] |=> m_err[m]);
      a_r9_word_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
         m_req[m] && m_size[m*2 +: 2] == 2'd2 && m_addr[m*32 +: 2] != 2'b00 |=> m_err[m]);
      a_r10_err_zero_rdata: assert property (@(posedge clk) disable iff (!rst_n)
         m_err[m] |-> m_rdata[m*32 +: 32] == '0);
      if (m != CPU_DATA_IDX) begin : g_guard
         a_r7_core_guard: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt[BANK_CORE][m]);
      end
   end

   always_comb begin
      granted = '0;
      for (int b = 0; b < NUM_BANKS; b++) granted |= gnt[b];
   end

   // per-bank arbitration, steering and storage
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      localparam int WORDS = words_of(b);
      localparam int IW    = $clog2(WORDS);
      logic [NUM_MASTERS-1:0] breq;
      logic [31:0]            sel_addr;
      logic [31:0]            sel_wdata;
      logic [1:0]             sel_size;
      logic                   sel_we;
      logic [31:0]            off;

      always_comb begin
         for (int m = 0; m < NUM_MASTERS; m++) breq[m] = hit[m][b];
      end

      sram_fixed_prio_arb #(.N(NUM_MASTERS)) u_arb (
         .clk  (clk),
         .rst_n(rst_n),
         .req  (breq),
         .gnt  (gnt[b])
      );

      always_comb begin
         sel_addr  = '0;
         sel_wdata = '0;
         sel_size  = '0;
         sel_we    = 1'b0;
         for (int m = 0; m < NUM_MASTERS; m++) begin
            if (gnt[b][m]) begin
               sel_addr  |= m_addr[m*32 +: 32];
               sel_wdata |= m_wdata[m*32 +: 32];
               sel_size  |= m_size[m*2 +: 2];
               sel_we    |= m_we[m];
            end
         end
      end

      assign off = sel_addr - bank_base(b);

      if (b == BANK_EXT && !HAS_EXT_BANK) begin : g_absent
         assign bank_rd[b] = '0;
      end else begin : g_present
         sram_bank_mem #(.WORDS(WORDS)) u_mem (
            .clk  (clk),
            .en   (|gnt[b]),
            .we   (sel_we),
            .idx  (IW'(off >> 2)),
            .be   (lane_enable(acc_size_t'(sel_size), sel_addr[1:0])),
            .wdata(lane_write(acc_size_t'(sel_size), sel_wdata)),
            .rdata(bank_rd[b])
         );
      end
   end

   a_r6_top_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
      m_ready[0]);

endmodule

// File: tb/sram_bank_router_test.sv
module sram_bank_router_test;

   localparam int NM = 3;
   localparam int W0 = 256, W1 = 128, W2 = 256, W3 = 256;
   localparam bit EXT = 1'b1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NM-1:0]     bm_req = '0;
   logic [32*NM-1:0]  bm_addr = '0;
   logic [2*NM-1:0]   bm_size = '0;
   logic [NM-1:0]     bm_we = '0;
   logic [32*NM-1:0]  bm_wdata = '0;
   logic [NM-1:0]     m_ready;
   logic [32*NM-1:0]  m_rdata;
   logic [NM-1:0]     m_err;

   int checks = 0;
   int failures = 0;

   logic [7:0]  mdl [4][1024];
   logic        got_ready [NM];
   logic        got_err [NM];
   logic [31:0] got_rdata [NM];

   always #4 clk = ~clk;

   sram_bank_router #(
      .NUM_MASTERS(NM), .CPU_DATA_IDX(0), .HAS_EXT_BANK(EXT),
      .MAIN_WORDS(W0), .SMALL_WORDS(W1), .CORE_WORDS(W2), .EXT_WORDS(W3)
   ) uut (
      .clk(clk), .rst_n(rst_n), .m_req(bm_req), .m_addr(bm_addr), .m_size(bm_size),
      .m_we(bm_we), .m_wdata(bm_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err)
   );

   function automatic int tb_bank(input logic [31:0] a);
      if (a >= 32'h2000_0000 && a < 32'h2001_C000) return 0;
      if (a >= 32'h2001_C000 && a < 32'h2002_0000) return 1;
      if (a >= 32'h1000_0000 && a < 32'h1001_0000) return 2;
      if (EXT && a >= 32'h2002_0000 && a < 32'h2003_0000) return 3;
      return -1;
   endfunction

   function automatic logic [31:0] tb_base(input int b);
      case (b)
         0: return 32'h2000_0000;
         1: return 32'h2001_C000;
         2: return 32'h1000_0000;
         default: return 32'h2002_0000;
      endcase
   endfunction

   function automatic int tb_bytes(input int b);
      case (b)
         0: return W0 * 4;
         1: return W1 * 4;
         2: return W2 * 4;
         default: return W3 * 4;
      endcase
   endfunction

   function automatic bit tb_ok(input int m, input logic [31:0] a, input logic [1:0] sz);
      int b;
      b = tb_bank(a);
      if (b < 0) return 0;
      if (b == 2 && m != 0) return 0;
      case (sz)
         2'd0: return 1;
         2'd1: return a[0] == 1'b0;
         2'd2: return a[1:0] == 2'b00;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] pat(input int b, input int i);
      return {8'hA0 + 8'(b), 8'(i), 8'h5A ^ 8'(i), 8'h3C ^ 8'(b)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_m(input int m, input logic rq, input logic [31:0] a,
                        input logic [1:0] sz, input logic w, input logic [31:0] d);
      bm_req[m] = rq;
      bm_addr[m*32 +: 32] = a;
      bm_size[m*2 +: 2] = sz;
      bm_we[m] = w;
      bm_wdata[m*32 +: 32] = d;
   endtask

   // one bus cycle: called at a falling edge with stimulus already set
   task automatic run_cycle();
      int          winner [4];
      bit          okm [NM];
      int          bk [NM];
      bit          exp_rdy [NM];
      bit          exp_err [NM];
      logic [31:0] exp_rd [NM];
      bit          do_wr [NM];
      #1;
      for (int b = 0; b < 4; b++) winner[b] = -1;
      for (int m = 0; m < NM; m++) begin
         okm[m] = bm_req[m] && tb_ok(m, bm_addr[m*32 +: 32], bm_size[m*2 +: 2]);
         bk[m] = tb_bank(bm_addr[m*32 +: 32]);
         if (okm[m] && winner[bk[m]] < 0) winner[bk[m]] = m;
      end
      for (int m = 0; m < NM; m++) begin
         logic [31:0] a;
         int off;
         a = bm_addr[m*32 +: 32];
         exp_rdy[m] = !(okm[m] && winner[bk[m]] != m);
         exp_err[m] = bm_req[m] && !okm[m];
         exp_rd[m] = '0;
         do_wr[m] = 0;
         if (okm[m] && winner[bk[m]] == m) begin
            off = int'(a - tb_base(bk[m])) % tb_bytes(bk[m]);
            if (bm_we[m]) do_wr[m] = 1;
            else for (int k = 0; k < (1 << bm_size[m*2 +: 2]); k++)
               exp_rd[m][k*8 +: 8] = mdl[bk[m]][off + k];
         end
         got_ready[m] = m_ready[m];
         check("R6 ready", {31'd0, m_ready[m]}, {31'd0, exp_rdy[m]});
      end
      @(posedge clk);
      for (int m = 0; m < NM; m++) begin
         if (do_wr[m]) begin
            int off;
            off = int'(bm_addr[m*32 +: 32] - tb_base(bk[m])) % tb_bytes(bk[m]);
            for (int k = 0; k < (1 << bm_size[m*2 +: 2]); k++)
               mdl[bk[m]][off + k] = bm_wdata[m*32 + k*8 +: 8];
         end
      end
      @(negedge clk);
      #1;
      for (int m = 0; m < NM; m++) begin
         got_err[m] = m_err[m];
         got_rdata[m] = m_rdata[m*32 +: 32];
         check("R8 err", {31'd0, m_err[m]}, {31'd0, exp_err[m]});
         check("R3 rdata", m_rdata[m*32 +: 32], exp_rd[m]);
      end
      bm_req = '0;
   endtask

   task automatic idle_all();
      for (int m = 0; m < NM; m++) set_m(m, 1'b0, 32'h0, 2'd0, 1'b0, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset state
      check("R10 reset err", {29'd0, m_err}, 32'd0);
      check("R10 reset rdata", m_rdata[31:0] | m_rdata[63:32] | m_rdata[95:64], 32'd0);
      check("R6 idle ready", {29'd0, m_ready}, 32'h7);
      @(negedge clk);

      // fill first 64 bytes of every bank through master 0
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 16; i++) begin
            idle_all();
            set_m(0, 1'b1, tb_base(b) + 32'(i * 4), 2'd2, 1'b1, pat(b, i));
            run_cycle();
         end

      // R1 / R4: small bank write then read by master 1
      idle_all(); set_m(1, 1'b1, 32'h2001_C004, 2'd2, 1'b1, 32'h5566_7788); run_cycle();
      idle_all(); set_m(1, 1'b1, 32'h2001_C004, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R1 small bank readback", got_rdata[1], 32'h5566_7788);
      check("R4 zero-wait ready", {31'd0, got_ready[1]}, 32'd1);
      idle_all(); set_m(2, 1'b1, 32'h2000_0000, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R1 main bank base", got_rdata[2], pat(0, 0));

      // R2: byte write on lane 1 of ext bank, word read back
      idle_all(); set_m(2, 1'b1, 32'h2002_0005, 2'd0, 1'b1, 32'hFFFF_FFEE); run_cycle();
      idle_all(); set_m(0, 1'b1, 32'h2002_0004, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R2 byte lane write", got_rdata[0], (pat(3, 1) & 32'hFFFF_00FF) | 32'h0000_EE00);
      // R3: halfword read of upper half
      idle_all(); set_m(0, 1'b1, 32'h2002_0006, 2'd1, 1'b0, 32'h0); run_cycle();
      check("R3 upper half read", got_rdata[0], {16'd0, pat(3, 1)[31:16]});
      idle_all(); set_m(1, 1'b1, 32'h2002_0005, 2'd0, 1'b0, 32'h0); run_cycle();
      check("R3 byte read", got_rdata[1], 32'h0000_00EE);

      // R5: different banks in the same cycle
      idle_all();
      set_m(0, 1'b1, 32'h2000_0020, 2'd2, 1'b0, 32'h0);
      set_m(2, 1'b1, 32'h2001_C020, 2'd2, 1'b0, 32'h0);
      run_cycle();
      check("R5 both ready", {30'd0, got_ready[2], got_ready[0]}, 32'd3);
      check("R5 dma data", got_rdata[2], pat(1, 8));

      // R6: same-bank conflicts
      idle_all();
      set_m(0, 1'b1, 32'h2000_0010, 2'd2, 1'b0, 32'h0);
      set_m(2, 1'b1, 32'h2000_0014, 2'd2, 1'b0, 32'h0);
      run_cycle();
      check("R6 loser stalled", {31'd0, got_ready[2]}, 32'd0);
      check("R6 loser no data", got_rdata[2], 32'd0);
      idle_all(); set_m(2, 1'b1, 32'h2000_0014, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R6 retry served", got_rdata[2], pat(0, 5));
      idle_all();
      set_m(1, 1'b1, 32'h2002_0008, 2'd2, 1'b1, 32'h1111_2222);
      set_m(2, 1'b1, 32'h2002_0008, 2'd2, 1'b1, 32'h3333_4444);
      run_cycle();
      check("R6 sys port beats dma", {30'd0, got_ready[2], got_ready[1]}, 32'd1);

      // R7: core bank rights
      idle_all(); set_m(2, 1'b1, 32'h1000_0008, 2'd2, 1'b1, 32'hDEAD_BEEF); run_cycle();
      check("R7 dma err", {31'd0, got_err[2]}, 32'd1);
      idle_all(); set_m(1, 1'b1, 32'h1000_0008, 2'd2, 1'b1, 32'hDEAD_BEEF); run_cycle();
      check("R7 sys port err", {31'd0, got_err[1]}, 32'd1);
      idle_all(); set_m(0, 1'b1, 32'h1000_0008, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R7 memory unchanged", got_rdata[0], pat(2, 2));

      // R8: unmapped
      idle_all(); set_m(1, 1'b1, 32'h3000_0000, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R8 unmapped err", {31'd0, got_err[1]}, 32'd1);
      check("R10 err rdata zero", got_rdata[1], 32'd0);
      idle_all(); set_m(0, 1'b1, 32'h2003_0000, 2'd2, 1'b1, 32'h0BAD_0BAD); run_cycle();
      check("R8 past ext err", {31'd0, got_err[0]}, 32'd1);

      // R9: alignment and bad size
      idle_all(); set_m(0, 1'b1, 32'h2000_0002, 2'd2, 1'b1, 32'hFFFF_FFFF); run_cycle();
      check("R9 word misaligned", {31'd0, got_err[0]}, 32'd1);
      idle_all(); set_m(0, 1'b1, 32'h2000_0001, 2'd1, 1'b1, 32'hFFFF_FFFF); run_cycle();
      check("R9 half misaligned", {31'd0, got_err[0]}, 32'd1);
      idle_all(); set_m(0, 1'b1, 32'h2000_0000, 2'd3, 1'b1, 32'hFFFF_FFFF); run_cycle();
      check("R9 size code 3", {31'd0, got_err[0]}, 32'd1);
      idle_all(); set_m(0, 1'b1, 32'h2000_0000, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R9 memory unchanged", got_rdata[0], pat(0, 0));

      // R11: aliasing beyond stored depth
      idle_all(); set_m(0, 1'b1, 32'h2000_0000 + 32'(W0 * 4) + 32'h8, 2'd2, 1'b1, 32'hCAFE_F00D); run_cycle();
      idle_all(); set_m(2, 1'b1, 32'h2000_0008, 2'd2, 1'b0, 32'h0); run_cycle();
      check("R11 alias", got_rdata[2], 32'hCAFE_F00D);

      // constrained random traffic
      for (int n = 0; n < 3000; n++) begin
         for (int m = 0; m < NM; m++) begin
            int sel;
            logic [1:0] sz;
            logic [31:0] a;
            int szr;
            sel = int'($urandom % 7);
            szr = int'($urandom % 8);
            sz = (szr < 2) ? 2'd0 : (szr < 4) ? 2'd1 : (szr < 7) ? 2'd2 : 2'd3;
            a = 32'(($urandom % 16) * 4);
            if (sz == 2'd0) a[1:0] = 2'($urandom);
            else if (sz == 2'd1) a[1] = 1'($urandom);
            if ($urandom % 10 == 0) a[1:0] = 2'($urandom);
            case (sel)
               0, 1, 2, 3: a = a + tb_base(sel);
               4: a = a + 32'h2000_0000 + 32'(W0 * 4);
               5: a = a + 32'h2000_0040;
               default: a = a + (($urandom % 2 == 0) ? 32'h3000_0000 : 32'h1001_0000);
            endcase
            if (sel == 5) a = a - 32'h40 + tb_base(int'($urandom % 4));
            set_m(m, 1'($urandom % 4 != 0), a, sz, 1'($urandom), $urandom);
         end
         run_cycle();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule